// File: doc/BRIEF.md
# Capacity-Aware Round-Robin Block Dispatcher

This block hands work groups (thread blocks) from an upstream queue to a set of streaming multiprocessors. Each request names how many threads the block needs and how many bytes of shared memory it reserves. For every multiprocessor the dispatcher keeps three running totals: resident blocks, resident threads and reserved shared memory. A multiprocessor is eligible only when one more block fits under all three limits. Among the eligible ones, the dispatcher grants the first one found when it searches upward from a rotating pointer, wrapping past the last index.

Upstream offers a block with a valid/ready pair. The grant happens in the same cycle as the handshake: the dispatch outputs name the chosen multiprocessor, and its totals take on the new block at the next clock edge. When a block finishes, a completion input names the multiprocessor and the thread and shared-memory amounts it gives back. That completion also frees one block slot. When no multiprocessor can take the offered block, ready stays low until a completion makes room.

Top module: `blk_sched_top`

## Requirements
- R1: After reset all usage totals are zero and the rotation pointer is 0, so the first accepted block goes to multiprocessor 0 and ready is high for any request that fits an empty multiprocessor.
- R2: The grant is the first eligible index found when searching from the rotation pointer upward, wrapping from NUM_SM-1 (default 30) to 0. After each grant the pointer becomes the granted index plus one, or 0 after the last index.
- R3: A multiprocessor that already holds MAX_BLK (default 8) resident blocks is skipped.
- R4: A multiprocessor is skipped when its resident threads plus the requested threads would exceed MAX_THR (default 1024). Reaching exactly MAX_THR is allowed.
- R5: A multiprocessor is skipped when its reserved shared memory plus the requested bytes would exceed SHMEM_BYTES (default 16384). Reaching exactly SHMEM_BYTES is allowed.
- R6: req_ready is high exactly when some multiprocessor is eligible. disp_valid is high in the cycle that req_valid and req_ready are both high, with disp_sm naming the grant in that cycle. The usage totals change at the following clock edge.
- R7: While no multiprocessor is eligible and no completion arrives, ready stays low for an unchanged request. Eligibility is judged on the registered totals, so a completion that frees room raises ready in the next cycle.
- R8: A completion subtracts one block, cmp_threads and cmp_shmem from multiprocessor cmp_sm. When a dispatch and a completion hit the same multiprocessor in the same cycle, both changes are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A block is offered |
| req_ready | output | 1 | Some multiprocessor can take the offered block |
| req_threads | input | THR_W (11) | Threads the offered block needs |
| req_shmem | input | SH_W (15) | Shared-memory bytes the offered block needs |
| disp_valid | output | 1 | Block granted this cycle |
| disp_sm | output | IDX_W (5) | Index of the granted multiprocessor |
| cmp_valid | input | 1 | A block has finished |
| cmp_sm | input | IDX_W (5) | Multiprocessor whose block finished |
| cmp_threads | input | THR_W (11) | Threads given back |
| cmp_shmem | input | SH_W (15) | Shared-memory bytes given back |

## Verification
A grant and a completion can land on the same multiprocessor in the same cycle, and that collision is the case that matters. The bench loads four multiprocessors with known totals. It then offers a block that will be granted to multiprocessor 0 in the same cycle that a completion returns an earlier block from multiprocessor 0. The result is judged only at the ports. Follow-up probes are sized so that one thread or one byte above the expected remaining room drops ready, while the exact remaining room is granted to multiprocessor 0. A lost completion or a lost dispatch therefore shows up as a wrong ready or a wrong index.

// File: rtl/blk_sched_pkg.sv
package blk_sched_pkg;

  // true when adding 'add' to 'used' stays within 'cap'
  function automatic logic fits(input int used, input int add, input int cap);
    return (used + add) <= cap;
  endfunction

  // index after 'idx' in a ring of 'n' entries
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/sm_usage.sv
module sm_usage #(
  parameter int MAX_BLK     = 8,
  parameter int MAX_THR     = 1024,
  parameter int SHMEM_BYTES = 16384,
  localparam int BLK_W = $clog2(MAX_BLK + 1),
  localparam int THR_W = $clog2(MAX_THR + 1),
  localparam int SH_W  = $clog2(SHMEM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] want_thr,
  input  logic [SH_W-1:0]  want_sh,
  input  logic             take_en,
  input  logic             give_en,
  input  logic [THR_W-1:0] give_thr,
  input  logic [SH_W-1:0]  give_sh,
  output logic [BLK_W-1:0] blk_cnt,
  output logic [THR_W-1:0] thr_cnt,
  output logic [SH_W-1:0]  sh_cnt,
  output logic             eligible
);
  import blk_sched_pkg::*;

  logic blk_room, thr_room, sh_room;

  always_comb begin
    blk_room = int'(blk_cnt) < MAX_BLK;
    thr_room = fits(int'(thr_cnt), int'(want_thr), MAX_THR);
    sh_room  = fits(int'(sh_cnt), int'(want_sh), SHMEM_BYTES);
    eligible = blk_room && thr_room && sh_room;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_cnt <= '0;
      thr_cnt <= '0;
      sh_cnt  <= '0;
    end else begin
      blk_cnt <= blk_cnt + BLK_W'(take_en) - BLK_W'(give_en);
      thr_cnt <= thr_cnt + (take_en ? want_thr : '0) - (give_en ? give_thr : '0);
      sh_cnt  <= sh_cnt  + (take_en ? want_sh  : '0) - (give_en ? give_sh  : '0);
    end
  end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 30,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     elig,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      idx = int'(start) + k;
      if (idx >= N) idx = idx - N;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/blk_sched_top.sv
module blk_sched_top #(
  parameter int NUM_SM      = 30,
  parameter int MAX_BLK     = 8,
  parameter int MAX_THR     = 1024,
  parameter int SHMEM_BYTES = 16384,
  localparam int IDX_W = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int BLK_W = $clog2(MAX_BLK + 1),
  localparam int THR_W = $clog2(MAX_THR + 1),
  localparam int SH_W  = $clog2(SHMEM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [THR_W-1:0] req_threads,
  input  logic [SH_W-1:0]  req_shmem,
  output logic             disp_valid,
  output logic [IDX_W-1:0] disp_sm,
  input  logic             cmp_valid,
  input  logic [IDX_W-1:0] cmp_sm,
  input  logic [THR_W-1:0] cmp_threads,
  input  logic [SH_W-1:0]  cmp_shmem
);
  import blk_sched_pkg::*;

  // named internal events for the checker
  logic [NUM_SM-1:0] elig_vec;
  logic [NUM_SM-1:0] take_vec;
  logic [NUM_SM-1:0] give_vec;
  logic              grant_fire;
  logic              any_fit;
  logic [IDX_W-1:0]  grant_idx;
  logic [IDX_W-1:0]  rr_ptr;
  logic [BLK_W-1:0]  blk_cnt [NUM_SM];
  logic [THR_W-1:0]  thr_cnt [NUM_SM];
  logic [SH_W-1:0]   sh_cnt  [NUM_SM];

  rr_pick #(.N(NUM_SM)) u_pick (
    .elig  (elig_vec),
    .start (rr_ptr),
    .found (any_fit),
    .pick  (grant_idx)
  );

  assign req_ready  = any_fit;
  assign grant_fire = req_valid && any_fit;
  assign disp_valid = grant_fire;
  assign disp_sm    = grant_idx;

  for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
    assign take_vec[g] = grant_fire && (grant_idx == IDX_W'(g));
    assign give_vec[g] = cmp_valid && (cmp_sm == IDX_W'(g));

    sm_usage #(
      .MAX_BLK     (MAX_BLK),
      .MAX_THR     (MAX_THR),
      .SHMEM_BYTES (SHMEM_BYTES)
    ) u_use (
      .clk      (clk),
      .rst_n    (rst_n),
      .want_thr (req_threads),
      .want_sh  (req_shmem),
      .take_en  (take_vec[g]),
      .give_en  (give_vec[g]),
      .give_thr (cmp_threads),
      .give_sh  (cmp_shmem),
      .blk_cnt  (blk_cnt[g]),
      .thr_cnt  (thr_cnt[g]),
      .sh_cnt   (sh_cnt[g]),
      .eligible (elig_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rr_ptr <= '0;
    else if (grant_fire) rr_ptr <= IDX_W'(ring_next(int'(grant_idx), NUM_SM));
  end

endmodule

// File: rtl/blk_sched_chk.sv
module blk_sched_chk #(
  parameter int NUM_SM      = 30,
  parameter int MAX_BLK     = 8,
  parameter int MAX_THR     = 1024,
  parameter int SHMEM_BYTES = 16384,
  localparam int IDX_W = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int BLK_W = $clog2(MAX_BLK + 1),
  localparam int THR_W = $clog2(MAX_THR + 1),
  localparam int SH_W  = $clog2(SHMEM_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [THR_W-1:0] req_threads,
  input logic [SH_W-1:0]  req_shmem,
  input logic             disp_valid,
  input logic [IDX_W-1:0] disp_sm,
  input logic             cmp_valid,
  input logic [IDX_W-1:0] cmp_sm,
  input logic [THR_W-1:0] cmp_threads,
  input logic [SH_W-1:0]  cmp_shmem,
  input logic [IDX_W-1:0] rr_ptr,
  input logic [BLK_W-1:0] blk_cnt [NUM_SM],
  input logic [THR_W-1:0] thr_cnt [NUM_SM],
  input logic [SH_W-1:0]  sh_cnt  [NUM_SM]
);

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !disp_valid) else $error("grant without request"); // R6

  AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (int'(disp_sm) < NUM_SM)) else $error("grant index out of range"); // R2

  AST_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> (int'(rr_ptr) == ((int'($past(disp_sm)) + 1) % NUM_SM)))
    else $error("pointer did not follow grant"); // R2

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !cmp_valid) ##1
    (req_valid && $stable(req_threads) && $stable(req_shmem)) |-> !req_ready)
    else $error("ready rose without a completion"); // R7

  // caps on every multiprocessor total
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NUM_SM; i++) begin
        AST_BLK_CAP: assert (int'(blk_cnt[i]) <= MAX_BLK) else $error("block cap SM%0d", i); // R3
        AST_THR_CAP: assert (int'(thr_cnt[i]) <= MAX_THR) else $error("thread cap SM%0d", i); // R4
        AST_SH_CAP: assert (int'(sh_cnt[i]) <= SHMEM_BYTES) else $error("shmem cap SM%0d", i); // R5
      end
    end
  end

  // same-cycle take and give on one multiprocessor
  logic             both_pend;
  logic [IDX_W-1:0] both_sm;
  int               both_thr, both_sh, both_blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      both_pend <= 1'b0;
      both_sm   <= '0;
      both_thr  <= 0;
      both_sh   <= 0;
      both_blk  <= 0;
    end else begin
      both_pend <= disp_valid && cmp_valid && (disp_sm == cmp_sm);
      both_sm   <= disp_sm;
      both_thr  <= int'(thr_cnt[disp_sm]) + int'(req_threads) - int'(cmp_threads);
      both_sh   <= int'(sh_cnt[disp_sm]) + int'(req_shmem) - int'(cmp_shmem);
      both_blk  <= int'(blk_cnt[disp_sm]);
    end
  end

  always @(posedge clk) begin
    if (rst_n && both_pend) begin
      AST_BOTH_APPLIED: assert (int'(thr_cnt[both_sm]) == both_thr &&
                                int'(sh_cnt[both_sm]) == both_sh &&
                                int'(blk_cnt[both_sm]) == both_blk)
        else $error("collision lost an update"); // R8
    end
  end

endmodule

bind blk_sched_top blk_sched_chk #(
  .NUM_SM      (NUM_SM),
  .MAX_BLK     (MAX_BLK),
  .MAX_THR     (MAX_THR),
  .SHMEM_BYTES (SHMEM_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_threads (req_threads),
  .req_shmem   (req_shmem),
  .disp_valid  (disp_valid),
  .disp_sm     (disp_sm),
  .cmp_valid   (cmp_valid),
  .cmp_sm      (cmp_sm),
  .cmp_threads (cmp_threads),
  .cmp_shmem   (cmp_shmem),
  .rr_ptr      (rr_ptr),
  .blk_cnt     (blk_cnt),
  .thr_cnt     (thr_cnt),
  .sh_cnt      (sh_cnt)
);

// File: tb/test_blk_sched_top.sv
module test_blk_sched_top;
  localparam int NSM   = 4;
  localparam int IDX_W = 2;
  localparam int THR_W = 11;
  localparam int SH_W  = 15;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [THR_W-1:0] req_threads;
  logic [SH_W-1:0]  req_shmem;
  logic             disp_valid;
  logic [IDX_W-1:0] disp_sm;
  logic             cmp_valid;
  logic [IDX_W-1:0] cmp_sm;
  logic [THR_W-1:0] cmp_threads;
  logic [SH_W-1:0]  cmp_shmem;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  blk_sched_top #(.NUM_SM(NSM)) i_blk_sched_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_shmem(req_shmem),
    .disp_valid(disp_valid), .disp_sm(disp_sm),
    .cmp_valid(cmp_valid), .cmp_sm(cmp_sm),
    .cmp_threads(cmp_threads), .cmp_shmem(cmp_shmem)
  );

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic [SH_W-1:0]  sh;
    logic [IDX_W-1:0] sm;
  } vec_t;

  // back-to-back grants from reset, no completions (R1 R2 R4 R5)
  localparam vec_t VT [10] = '{
    '{11'd1024, 15'd0,     2'd0},  // R1 first grant to 0
    '{11'd10,   15'd16384, 2'd1},
    '{11'd10,   15'd0,     2'd2},
    '{11'd10,   15'd0,     2'd3},  // wrap next
    '{11'd10,   15'd0,     2'd1},  // R4 SM0 thread-full skipped
    '{11'd10,   15'd1,     2'd2},
    '{11'd10,   15'd1,     2'd3},
    '{11'd1,    15'd1,     2'd2},  // R4 R5 SM0 and SM1 skipped
    '{11'd0,    15'd16384, 2'd0},  // R4 exact thread cap allowed, R5 SM3 skipped
    '{11'd1,    15'd0,     2'd1}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; cmp_valid = 1'b0;
    req_threads = '0; req_shmem = '0; cmp_sm = '0; cmp_threads = '0; cmp_shmem = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic rv, input int thr, input int sh,
                      input logic cv, input int csm, input int cthr, input int csh,
                      input logic exp_rdy, input int exp_sm, input string tag);
    @(negedge clk);
    req_valid = rv; req_threads = THR_W'(thr); req_shmem = SH_W'(sh);
    cmp_valid = cv; cmp_sm = IDX_W'(csm); cmp_threads = THR_W'(cthr); cmp_shmem = SH_W'(csh);
    #5;
    chk(req_ready == exp_rdy, {tag, " ready"}, int'(req_ready), int'(exp_rdy));
    if (rv && exp_rdy)
      chk(disp_valid && int'(disp_sm) == exp_sm, {tag, " grant"}, int'(disp_sm), exp_sm);
    else
      chk(!disp_valid, {tag, " no grant"}, int'(disp_valid), 0);
    @(posedge clk);
    #1;
    req_valid = 1'b0; cmp_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle after reset, empty request fits
    step(1'b0, 0, 0, 1'b0, 0, 0, 0, 1'b1, 0, "R1 reset idle");

    for (int i = 0; i < 10; i++)
      step(1'b1, int'(VT[i].thr), int'(VT[i].sh), 1'b0, 0, 0, 0, 1'b1, int'(VT[i].sm),
           $sformatf("R2 table %0d", i));

    // R3: fill every block slot, rotation 0..3
    do_reset();
    for (int i = 0; i < 8 * NSM; i++)
      step(1'b1, 0, 0, 1'b0, 0, 0, 0, 1'b1, i % NSM, $sformatf("R3 fill %0d", i));
    // R7: nothing eligible, ready held low
    for (int i = 0; i < 3; i++)
      step(1'b1, 0, 0, 1'b0, 0, 0, 0, 1'b0, 0, "R3 R7 full hold");
    // completion to SM2 in the same cycle: ready still low (registered totals)
    step(1'b1, 0, 0, 1'b1, 2, 0, 0, 1'b0, 0, "R7 completion cycle");
    step(1'b1, 0, 0, 1'b0, 0, 0, 0, 1'b1, 2, "R7 R8 freed slot");

    // R8: same-cycle grant and completion on SM0
    do_reset();
    step(1'b1, 100, 1000, 1'b0, 0, 0, 0, 1'b1, 0, "R8 load A");
    step(1'b1, 200, 2000, 1'b0, 0, 0, 0, 1'b1, 1, "R8 load B");
    step(1'b1, 300, 3000, 1'b0, 0, 0, 0, 1'b1, 2, "R8 load C");
    step(1'b1, 900, 1,    1'b0, 0, 0, 0, 1'b1, 3, "R8 load D");
    step(1'b1, 50,  500,  1'b1, 0, 100, 1000, 1'b1, 0, "R8 collide");
    // SM0 now holds 50 threads and 500 bytes
    step(1'b1, 975, 0,     1'b0, 0, 0, 0, 1'b0, 0, "R8 R4 one thread over");
    step(1'b1, 974, 15885, 1'b0, 0, 0, 0, 1'b0, 0, "R8 R5 one byte over");
    step(1'b1, 974, 15884, 1'b0, 0, 0, 0, 1'b1, 0, "R8 exact room");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule